// File: doc/BRIEF.md
# Keyed Watchdog Timer with Interrupt Pre-Warning

This block guards a system against a hung processor. A power-of-two prescaler turns the fast system clock into a slow tick. An 8-bit down-counter decrements once per tick while the watchdog runs. When the counter reaches 1, the block raises a non-maskable interrupt request, which gives software one last tick to react. When the counter reaches 0, the block emits a single-cycle system reset pulse and returns to the stopped state.

Software drives the block through one write port. Each write carries a count, a command (start or stop) and a 7-bit key. A write is accepted only if its key is the bitwise inverse of the key from the last accepted write. The only exception is the very first start after reset, which may use any key. A stray or runaway write therefore cannot keep the watchdog alive or stop it. A write with the wrong key is dropped and leaves a sticky error flag behind. The running flag, the current count and the error flag can be read back.

Top module: `kwdog_top`

## Requirements
- R1: After reset, running_o, count_o, nmi_o, bite_o and key_err_o are all 0, and no reference key is held.
- R2: While no reference key is held, a start write (wr_cmd=1) with any key is accepted and its key becomes the reference. A stop write (wr_cmd=0) in that state is rejected.
- R3: Once a reference key is held, a write of either command is accepted only if wr_key equals the reference XOR 7'h7F. An accepted write replaces the reference with its own key. A rejected write changes neither the running flag, the count, nmi_o nor the reference key.
- R4: A rejected write sets key_err_o, and key_err_o stays 1 until reset.
- R5: An accepted start loads count_o from wr_count in the cycle after the write, sets running_o and clears the prescaler. A start on a running watchdog behaves exactly like a first start.
- R6: While running, count_o decrements once every 2**PRESCALE_LOG2 cycles. The first decrement comes exactly 2**PRESCALE_LOG2 cycles after the edge that captured the start.
- R7: nmi_o is 1 exactly while running_o is 1 and count_o is 1. This includes a start that loads 1. nmi_o stays high until a reload, a stop or expiry.
- R8: A tick that arrives while running with count_o at 1 or 0 produces a one-cycle bite_o pulse. In that same cycle running_o falls and count_o becomes 0.
- R9: An accepted stop clears running_o and nmi_o and holds count_o. No bite_o follows, however long the block waits.
- R10: The reference key survives an expiry. The next start must still present its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_cmd | input | 1 | 1 = start/reload, 0 = stop |
| wr_count | input | 8 | Count loaded by a start |
| wr_key | input | 7 | Key carried by the write |
| running_o | output | 1 | Watchdog is counting |
| count_o | output | 8 | Current counter value |
| key_err_o | output | 1 | Sticky flag for a rejected write |
| nmi_o | output | 1 | Non-maskable interrupt request (pre-warning) |
| bite_o | output | 1 | One-cycle system reset pulse on expiry |

## Verification
The hardest situations to reach are the one-tick warning window and the moments around it: a restart or a wrong-key stop that lands while nmi_o is already high, and an expiry followed by a start that reuses the old key. The bench shrinks the prescaler to eight cycles. It counts cycles from the edge that captured each start, so that it can place writes inside the warning window and sample the exact cycles of the warning, the bite and the reload.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
    typedef enum logic {
        CMD_STOP  = 1'b0,
        CMD_START = 1'b1
    } wd_cmd_e;

    localparam int KEY_W = 7;
    localparam logic [KEY_W-1:0] KEY_FLIP = '1;
endpackage

// File: rtl/kwdog_prescaler.sv
module kwdog_prescaler #(
    parameter int DIV_LOG2 = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    typedef struct packed {
        logic [DIV_LOG2-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr) begin
            pre_d.cnt = '0;
        end else if (en) begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    assign tick = en && !clr && (&pre_q.cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/kwdog_keygate.sv
module kwdog_keygate
    import kwdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [KEY_W-1:0] wr_key,
    output logic             accept,
    output logic             reject
);
    typedef struct packed {
        logic             have;
        logic [KEY_W-1:0] key;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  key_ok;

    always_comb begin
        if (gate_q.have) key_ok = (wr_key == (gate_q.key ^ KEY_FLIP));
        else             key_ok = (wr_cmd == CMD_START);
        accept = wr_en && key_ok;
        reject = wr_en && !key_ok;
        gate_d = gate_q;
        if (accept) begin
            gate_d.have = 1'b1;
            gate_d.key  = wr_key;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
    import kwdog_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int PRESCALE_LOG2 = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [KEY_W-1:0] wr_key,
    output logic             running_o,
    output logic [CNT_W-1:0] count_o,
    output logic             key_err_o,
    output logic             nmi_o,
    output logic             bite_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             nmi;
        logic             bite;
        logic             err;
    } core_t;

    core_t core_d, core_q;
    logic  accept, reject, tick, do_start;

    kwdog_keygate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_cmd (wr_cmd),
        .wr_key (wr_key),
        .accept (accept),
        .reject (reject)
    );

    assign do_start = accept && (wr_cmd == CMD_START);

    kwdog_prescaler #(.DIV_LOG2(PRESCALE_LOG2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (core_q.run),
        .clr   (do_start),
        .tick  (tick)
    );

    always_comb begin
        core_d      = core_q;
        core_d.bite = 1'b0;
        if (reject) core_d.err = 1'b1;
        if (accept) begin
            if (do_start) begin
                core_d.run = 1'b1;
                core_d.cnt = wr_count;
            end else begin
                core_d.run = 1'b0;
            end
        end else if (core_q.run && tick) begin
            if (core_q.cnt <= CNT_ONE) begin
                core_d.run  = 1'b0;
                core_d.cnt  = '0;
                core_d.bite = 1'b1;
            end else begin
                core_d.cnt = core_q.cnt - 1'b1;
            end
        end
        core_d.nmi = core_d.run && (core_d.cnt == CNT_ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign running_o = core_q.run;
    assign count_o   = core_q.cnt;
    assign key_err_o = core_q.err;
    assign nmi_o     = core_q.nmi;
    assign bite_o    = core_q.bite;
endmodule

// File: rtl/kwdog_checker.sv
module kwdog_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             running_o,
    input logic [CNT_W-1:0] count_o,
    input logic             key_err_o,
    input logic             nmi_o,
    input logic             bite_o
);
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_err_o |=> key_err_o);

    assert_nmi_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> (running_o && count_o == CNT_W'(1)));

    assert_bite_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bite_o |=> !bite_o);

    assert_bite_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bite_o |-> (!running_o && count_o == '0 && !nmi_o));

    assert_bite_from_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !bite_o) |=> !bite_o);

    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !wr_en) |=> $stable(count_o));

    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !wr_en && count_o > CNT_W'(1)) |=>
            (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1));
endmodule

bind kwdog_top kwdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .running_o (running_o),
    .count_o   (count_o),
    .key_err_o (key_err_o),
    .nmi_o     (nmi_o),
    .bite_o    (bite_o)
);

// File: tb/sim_kwdog_top.sv
`timescale 1ns/1ps
module sim_kwdog_top;
    localparam int PL2 = 3;
    localparam int DIV = 1 << PL2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [7:0] wr_count = '0;
    logic [6:0] wr_key = '0;
    logic       running_o, key_err_o, nmi_o, bite_o;
    logic [7:0] count_o;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    kwdog_top #(.CNT_W(8), .PRESCALE_LOG2(PL2)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_count(wr_count), .wr_key(wr_key), .running_o(running_o),
        .count_o(count_o), .key_err_o(key_err_o), .nmi_o(nmi_o), .bite_o(bite_o)
    );

    typedef struct packed {
        logic       cmd;
        logic [7:0] cnt;
        logic [6:0] key;
        logic       e_run;
        logic [7:0] e_cnt;
        logic       e_err;
    } vec_t;

    // R2 stop first rejected, R2 any first key, R3 wrong key ignored, R3 stop needs inverse
    localparam vec_t VECS [7] = '{
        '{1'b0, 8'd9,  7'h00, 1'b0, 8'd0,  1'b1},
        '{1'b1, 8'd20, 7'h2A, 1'b1, 8'd20, 1'b1},
        '{1'b1, 8'd30, 7'h2A, 1'b1, 8'd20, 1'b1},
        '{1'b1, 8'd40, 7'h55, 1'b1, 8'd40, 1'b1},
        '{1'b0, 8'd0,  7'h55, 1'b1, 8'd40, 1'b1},
        '{1'b0, 8'd0,  7'h2A, 1'b0, 8'd40, 1'b1},
        '{1'b1, 8'd5,  7'h55, 1'b1, 8'd5,  1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drives one write; returns half a cycle after the edge that captured it.
    task automatic wr(input logic cmd, input logic [7:0] cnt, input logic [6:0] key);
        wr_en = 1'b1; wr_cmd = cmd; wr_count = cnt; wr_key = key;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int pulses;
        do_reset();
        chk("R1 running", running_o, 0);
        chk("R1 count", count_o, 0);
        chk("R1 nmi/bite/err", {nmi_o, bite_o, key_err_o}, 0);

        foreach (VECS[i]) begin
            wr(VECS[i].cmd, VECS[i].cnt, VECS[i].key);
            chk($sformatf("R3 vec%0d running", i), running_o, VECS[i].e_run);
            chk($sformatf("R3 vec%0d count", i), count_o, VECS[i].e_cnt);
            chk($sformatf("R4 vec%0d err", i), key_err_o, VECS[i].e_err);
        end

        // R6/R7/R8 timing from a fresh start with count 3
        do_reset();
        chk("R1 err cleared", key_err_o, 0);
        wr(1'b1, 8'd3, 7'h11);
        chk("R5 load", {running_o, count_o}, {1'b1, 8'd3});
        adv(DIV - 1);
        chk("R6 before tick", count_o, 3);
        adv(1);
        chk("R6 first tick", count_o, 2);
        adv(DIV - 1);
        chk("R7 no early nmi", nmi_o, 0);
        adv(1);
        chk("R7 nmi at 1", {nmi_o, count_o}, {1'b1, 8'd1});
        adv(DIV - 1);
        chk("R8 no early bite", {bite_o, nmi_o}, 2'b01);
        adv(1);
        chk("R8 bite", {bite_o, running_o, nmi_o, count_o}, {3'b100, 8'd0});
        adv(1);
        chk("R8 single pulse", bite_o, 0);

        // R10 reference key kept across expiry
        wr(1'b1, 8'd2, 7'h11);
        chk("R10 old key rejected", {running_o, key_err_o}, 2'b01);
        wr(1'b1, 8'd2, 7'h6E);
        chk("R10 inverse accepted", {running_o, count_o}, {1'b1, 8'd2});
        adv(DIV);
        chk("R7 nmi window", nmi_o, 1);
        wr(1'b0, 8'd0, 7'h6E);
        chk("R3 wrong stop ignored", {running_o, nmi_o}, 2'b11);
        wr(1'b1, 8'd4, 7'h11);
        chk("R5 restart in window", {nmi_o, count_o}, {1'b0, 8'd4});
        adv(DIV - 1);
        chk("R5 prescaler cleared", count_o, 4);
        adv(1);
        chk("R6 restart tick", count_o, 3);
        wr(1'b0, 8'd0, 7'h6E);
        chk("R9 stop", {running_o, nmi_o, count_o}, {2'b00, 8'd3});
        pulses = 0;
        for (int c = 0; c < 6 * DIV; c++) begin
            @(negedge clk);
            if (bite_o) pulses++;
        end
        chk("R9 no bite after stop", pulses, 0);
        chk("R9 count held", count_o, 3);

        wr(1'b1, 8'd1, 7'h11);
        chk("R7 load of one", {nmi_o, running_o}, 2'b11);
        adv(DIV);
        chk("R8 expiry from one", {bite_o, running_o}, 2'b10);
        chk("R4 still sticky", key_err_o, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule